// File: doc/BRIEF.md
# Programmable Waveform Descriptor Sequencer

This block is a small programmable engine that plays out an interface waveform stored in a descriptor table. A host loads the table through a byte-wide write port. The table holds eight slots. Slots 0 to 6 are programmable, and slot 7 is a fixed idle state. Each programmable slot is one of two kinds. A timed slot drives six control outputs for a programmed number of clocks and then falls through to the next slot. A decision slot lasts one clock. It may capture the parallel data bus into a downstream FIFO, and it branches to one of two slots on a selectable logic function of two status terms. One of those terms is FIFO-full.

A run starts when `go` is pulsed while the engine is idle with a nonzero pass count. Each time execution reaches slot 7, one pass ends. If passes remain, the waveform restarts at slot 0 in the next clock. After the last pass, the engine parks in idle and raises `done`.

Samples leave on a valid/ready port. `fifo_valid` is raised only in a capture cycle in which `fifo_ready` is high. A sample offered while `fifo_ready` is low is dropped and is not held for a later cycle, so the engine never stalls on the FIFO. A low `fifo_ready` is also the FIFO-full status term, and the waveform branches on it.

Top module: `wfseq_top`

## Requirements
- R1: Descriptor write address bits [4:3] select the byte kind: 0 is length/branch, 1 is opcode, 2 is output and 3 is logic. Bits [2:0] select the slot. A write takes effect only while `done` is 1 and is ignored otherwise.
- R2: After reset, and whenever the engine is in slot 7, `done` is 1, `ctl_out` is 0 and `fifo_valid` is 0.
- R3: A `go` pulse while idle with `xfer_count` nonzero enters slot 0 on the next clock. A `go` pulse with a count of 0 leaves the engine idle.
- R4: A slot whose opcode bit 0 is 0 is a timed slot. It lasts as many clocks as its length byte, where 0 means 256. It drives output byte bits [5:0] on `ctl_out` and then moves to slot+1.
- R5: A slot whose opcode bit 0 is 1 is a decision slot and lasts one clock. Next, it goes to branch bits [5:3] when the condition is true and to bits [2:0] when the condition is false.
- R6: Logic byte bits [7:6] select the function: 0 is A AND B, 1 is A OR B, 2 is A XOR B, 3 is (NOT A) AND B. Term A is chosen by bits [5:3] and term B by bits [2:0]. Term codes 0 to 5 select `rdy_in[code]`. Code 6 is FIFO-full (`fifo_ready` low). Code 7 is true during the last pass.
- R7: A decision slot with opcode bit 1 set raises `fifo_valid`, with `fifo_data` equal to `data_in`, in its cycle, but only while `fifo_ready` is 1.
- R8: Branch bit 7 is the re-execute flag. When it is clear, a decision slot that has just branched to itself does not capture again. When it is set, the slot captures on every cycle of the self-loop.
- R9: Reaching slot 7 while passes remain restarts slot 0, so the waveform runs `xfer_count` times before `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_we | input | 1 | Descriptor byte write strobe |
| desc_addr | input | 5 | Descriptor byte address {kind, slot} |
| desc_wdata | input | 8 | Descriptor byte value |
| go | input | 1 | Start pulse, honoured only while idle |
| xfer_count | input | 16 | Number of waveform passes |
| done | output | 1 | Engine is idle |
| ctl_out | output | 6 | Control outputs |
| rdy_in | input | 6 | External status terms 0 to 5 |
| data_in | input | 8 | Parallel data bus |
| fifo_valid | output | 1 | Sample offered to the FIFO |
| fifo_data | output | 8 | Sample value |
| fifo_ready | input | 1 | FIFO can accept; low means full |

## Verification
The re-execute behaviour is the hardest to reach. It needs a decision slot that branches to itself for several cycles while capture is enabled, and then leaves the loop on a term the bench controls. The stimulus builds a one-slot capture loop that exits on FIFO-full. It holds `fifo_ready` high for a known number of cycles and then drops it, so the number of accepted samples tells the two flag settings apart. The pass restart is reached with a short timed slot followed by a capture slot, run with a count of three.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
  typedef logic [2:0] slot_t;
  localparam slot_t IDLE_SLOT = 3'd7;
  localparam int    N_RDY     = 6;

  typedef enum logic [1:0] {
    LF_AND  = 2'd0,
    LF_OR   = 2'd1,
    LF_XOR  = 2'd2,
    LF_NAB  = 2'd3
  } lfunc_e;

  localparam int BK_LEN = 0;
  localparam int BK_OP  = 1;
  localparam int BK_OUT = 2;
  localparam int BK_LOG = 3;

  localparam int OPB_DP   = 0;
  localparam int OPB_DATA = 1;
endpackage

// File: rtl/wfs_desc_mem.sv
module wfs_desc_mem #(
  parameter int BYTE_W = 8,
  parameter int SLOT_W = 3,
  parameter int BANKS  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [$clog2(BANKS)+SLOT_W-1:0] waddr,
  input  logic [BYTE_W-1:0]             wdata,
  input  logic                          wr_allow,
  input  logic [SLOT_W-1:0]             rd_slot,
  output logic [BANKS-1:0][BYTE_W-1:0]  rd_bytes
);
  localparam int SLOTS = 1 << SLOT_W;
  localparam int AW    = $clog2(BANKS) + SLOT_W;

  logic [BYTE_W-1:0] mem [BANKS][SLOTS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic hit;
      assign hit = we && (waddr == AW'(b * SLOTS + s));

      always_ff @(posedge clk) begin
        if (!rst_n)               mem[b][s] <= '0;
        else if (hit && wr_allow) mem[b][s] <= wdata;
      end

      // R1
      desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wr_allow) |=> $stable(mem[b][s]));
    end
    assign rd_bytes[b] = mem[b][rd_slot];
  end
endmodule

// File: rtl/wfs_term_eval.sv
module wfs_term_eval
  import wfs_pkg::*;
(
  input  logic [N_RDY-1:0] rdy,
  input  logic             fifo_full,
  input  logic             tc_last,
  input  logic [7:0]       logic_byte,
  output logic             cond
);
  logic [N_RDY+1:0] terms;
  logic             ta, tb;
  lfunc_e           fn;

  assign terms = {tc_last, fifo_full, rdy};
  assign ta    = terms[logic_byte[5:3]];
  assign tb    = terms[logic_byte[2:0]];
  assign fn    = lfunc_e'(logic_byte[7:6]);

  always_comb begin
    unique case (fn)
      LF_AND:  cond = ta & tb;
      LF_OR:   cond = ta | tb;
      LF_XOR:  cond = ta ^ tb;
      default: cond = ~ta & tb;
    endcase
  end
endmodule

// File: rtl/wfs_seq_core.sv
module wfs_seq_core
  import wfs_pkg::*;
#(
  parameter int TC_W   = 16,
  parameter int CTL_W  = 6,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [TC_W-1:0]   xfer_count,
  input  logic [BYTE_W-1:0] len_b,
  input  logic              op_dp,
  input  logic              op_data,
  input  logic [CTL_W-1:0]  out_b,
  input  logic              cond,
  input  logic              fifo_ready,
  output slot_t             cur,
  output logic              done,
  output logic              tc_last,
  output logic [CTL_W-1:0]  ctl,
  output logic              capture
);
  logic [BYTE_W-1:0] cnt;
  logic [TC_W-1:0]   tc_rem;
  logic              self_rep;
  logic              adv, expired, start_ok;
  slot_t             tgt;

  assign done     = (cur == IDLE_SLOT);
  assign tc_last  = (tc_rem == TC_W'(1));
  assign expired  = (cnt == BYTE_W'(len_b - 1'b1));
  assign start_ok = go && (xfer_count != '0);

  always_comb begin
    adv = 1'b0;
    tgt = cur;
    if (!done) begin
      if (op_dp) begin
        adv = 1'b1;
        tgt = cond ? slot_t'(len_b[5:3]) : slot_t'(len_b[2:0]);
      end else if (expired) begin
        adv = 1'b1;
        tgt = slot_t'(cur + 3'd1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= IDLE_SLOT;
      cnt      <= '0;
      tc_rem   <= '0;
      self_rep <= 1'b0;
    end else if (done) begin
      cnt      <= '0;
      self_rep <= 1'b0;
      if (start_ok) begin
        cur    <= '0;
        tc_rem <= xfer_count;
      end
    end else if (adv) begin
      cnt      <= '0;
      self_rep <= op_dp && (tgt == cur);
      if (tgt == IDLE_SLOT && !tc_last) begin
        cur    <= '0;
        tc_rem <= tc_rem - 1'b1;
      end else begin
        cur <= tgt;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign capture = !done && op_dp && op_data && fifo_ready && (len_b[7] || !self_rep);
  assign ctl     = done ? '0 : out_b;

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_ok) |=> done);

  // R3
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start_ok) |=> (!done && cur == '0));

  // R4
  delay_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !op_dp) |=> (cur == $past(cur) || cur == slot_t'($past(cur) + 3'd1) || cur == '0));
endmodule

// File: rtl/wfseq_top.sv
module wfseq_top
  import wfs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TC_W   = 16,
  parameter int CTL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_we,
  input  logic [4:0]        desc_addr,
  input  logic [7:0]        desc_wdata,
  input  logic              go,
  input  logic [TC_W-1:0]   xfer_count,
  output logic              done,
  output logic [CTL_W-1:0]  ctl_out,
  input  logic [N_RDY-1:0]  rdy_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              fifo_valid,
  output logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_ready
);
  localparam int BYTE_W = 8;
  localparam int BANKS  = 4;

  logic [BANKS-1:0][BYTE_W-1:0] bytes;
  slot_t cur;
  logic  cond, tc_last;
  logic  unused_bits;

  assign unused_bits = ^{bytes[BK_OP][7:2], bytes[BK_OUT][7:CTL_W]};

  wfs_desc_mem #(.BYTE_W(BYTE_W), .SLOT_W(3), .BANKS(BANKS)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (desc_we),
    .waddr    (desc_addr),
    .wdata    (desc_wdata),
    .wr_allow (done),
    .rd_slot  (cur),
    .rd_bytes (bytes)
  );

  wfs_term_eval u_term (
    .rdy        (rdy_in),
    .fifo_full  (!fifo_ready),
    .tc_last    (tc_last),
    .logic_byte (bytes[BK_LOG]),
    .cond       (cond)
  );

  wfs_seq_core #(.TC_W(TC_W), .CTL_W(CTL_W), .BYTE_W(BYTE_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .xfer_count (xfer_count),
    .len_b      (bytes[BK_LEN]),
    .op_dp      (bytes[BK_OP][OPB_DP]),
    .op_data    (bytes[BK_OP][OPB_DATA]),
    .out_b      (bytes[BK_OUT][CTL_W-1:0]),
    .cond       (cond),
    .fifo_ready (fifo_ready),
    .cur        (cur),
    .done       (done),
    .tc_last    (tc_last),
    .ctl        (ctl_out),
    .capture    (fifo_valid)
  );

  assign fifo_data = data_in;

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ctl_out == '0 && !fifo_valid));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid |-> fifo_ready);
endmodule

// File: tb/wfseq_top_test.sv
`timescale 1ns/1ps
module wfseq_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_we = 1'b0;
  logic [4:0]  desc_addr = '0;
  logic [7:0]  desc_wdata = '0;
  logic        go = 1'b0;
  logic [15:0] xfer_count = '0;
  logic        done;
  logic [5:0]  ctl_out;
  logic [5:0]  rdy_in = '0;
  logic [7:0]  data_in = '0;
  logic        fifo_valid;
  logic [7:0]  fifo_data;
  logic        fifo_ready = 1'b1;

  int checks = 0;
  int fails  = 0;
  int wr_cnt = 0;
  logic [7:0] last_data = '0;

  always #2.5 clk = ~clk;

  wfseq_top uut (
    .clk(clk), .rst_n(rst_n), .desc_we(desc_we), .desc_addr(desc_addr),
    .desc_wdata(desc_wdata), .go(go), .xfer_count(xfer_count), .done(done),
    .ctl_out(ctl_out), .rdy_in(rdy_in), .data_in(data_in),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_ready(fifo_ready)
  );

  always @(posedge clk) if (fifo_valid && fifo_ready) begin
    wr_cnt    <= wr_cnt + 1;
    last_data <= fifo_data;
  end

  // {lfunc[1:0], termA[2:0], termB[2:0], rdy[5:0], expected condition}
  localparam logic [14:0] VEC [10] = '{
    {2'd0, 3'd0, 3'd1, 6'b000011, 1'b1},
    {2'd0, 3'd0, 3'd1, 6'b000001, 1'b0},
    {2'd1, 3'd2, 3'd3, 6'b000100, 1'b1},
    {2'd1, 3'd2, 3'd3, 6'b000000, 1'b0},
    {2'd2, 3'd4, 3'd5, 6'b010000, 1'b1},
    {2'd2, 3'd4, 3'd5, 6'b110000, 1'b0},
    {2'd3, 3'd0, 3'd5, 6'b100000, 1'b1},
    {2'd3, 3'd0, 3'd5, 6'b100001, 1'b0},
    {2'd0, 3'd6, 3'd6, 6'b000000, 1'b0},
    {2'd0, 3'd7, 3'd7, 6'b000000, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    desc_we = 1'b1; desc_addr = a; desc_wdata = d;
    @(negedge clk);
    desc_we = 1'b0;
  endtask

  // kind: 0 len/branch, 1 opcode, 2 output, 3 logic
  task automatic slot(input int s, input logic [7:0] len, input logic [7:0] op,
                      input logic [7:0] outb, input logic [7:0] lg);
    wr({2'd0, 3'(s)}, len);
    wr({2'd1, 3'(s)}, op);
    wr({2'd2, 3'(s)}, outb);
    wr({2'd3, 3'(s)}, lg);
  endtask

  task automatic start(input logic [15:0] n);
    @(negedge clk);
    go = 1'b1; xfer_count = n;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (!done && k < 5000) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int base, n11, n22, n3f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b1, "R2 reset done", done, 1);
    chk(ctl_out == 6'd0, "R2 reset ctl", ctl_out, 0);
    chk(fifo_valid == 1'b0, "R2 reset valid", fifo_valid, 0);

    // Vector walk: slot0 decides, true -> 1 (0x15), false -> 5 (0x2A)
    slot(0, 8'h0D, 8'h01, 8'h00, 8'h00);
    slot(1, 8'h01, 8'h00, 8'h15, 8'h00);
    slot(2, 8'h3F, 8'h01, 8'h00, 8'h00);
    slot(5, 8'h01, 8'h00, 8'h2A, 8'h00);
    slot(6, 8'h01, 8'h00, 8'h00, 8'h00);
    for (int i = 0; i < 10; i++) begin
      logic [14:0] v;
      v = VEC[i];
      wr({2'd3, 3'd0}, {v[14:13], v[12:10], v[9:7]});
      rdy_in = v[6:1];
      start(16'd1);
      @(negedge clk);
      chk(ctl_out == (v[0] ? 6'h15 : 6'h2A), $sformatf("R5 R6 vector %0d", i),
          ctl_out, v[0] ? 6'h15 : 6'h2A);
      wait_idle();
    end
    rdy_in = '0;

    // Timed slots, zero delay = 256, capture, write ignored while busy
    slot(0, 8'h03, 8'h00, 8'h11, 8'h00);
    slot(1, 8'h00, 8'h00, 8'h22, 8'h00);
    slot(2, 8'h3F, 8'h03, 8'h00, 8'h36);
    data_in = 8'hA5;
    base = wr_cnt;
    n11 = 0; n22 = 0; n3f = 0;
    start(16'd1);
    for (int k = 0; k < 400 && !done; k++) begin
      if (ctl_out == 6'h11) n11++;
      if (ctl_out == 6'h22) n22++;
      if (ctl_out == 6'h3F) n3f++;
      desc_we = (k == 0); desc_addr = {2'd2, 3'd1}; desc_wdata = 8'h3F;
      @(negedge clk);
    end
    desc_we = 1'b0;
    chk(n11 == 3, "R4 delay 3", n11, 3);
    chk(n22 == 256, "R4 delay 0 means 256", n22, 256);
    chk(n3f == 0, "R1 busy write ignored", n3f, 0);
    chk(wr_cnt - base == 1, "R7 one capture", wr_cnt - base, 1);
    chk(last_data == 8'hA5, "R7 captured data", last_data, 8'hA5);
    chk(done && ctl_out == 0, "R2 idle after run", ctl_out, 0);

    // Capture suppressed while full
    fifo_ready = 1'b0;
    base = wr_cnt;
    start(16'd1);
    wait_idle();
    fifo_ready = 1'b1;
    chk(wr_cnt - base == 0, "R7 no write when full", wr_cnt - base, 0);
    chk(done == 1'b1, "R2 run ends while full", done, 1);

    // Count of zero ignored
    start(16'd0);
    chk(done == 1'b1, "R3 zero count ignored", done, 1);

    // Pass count 3
    slot(0, 8'h02, 8'h00, 8'h01, 8'h00);
    slot(1, 8'h3F, 8'h03, 8'h00, 8'h36);
    base = wr_cnt;
    start(16'd3);
    chk(!done && ctl_out == 6'h01, "R3 start in slot 0", ctl_out, 1);
    wait_idle();
    chk(wr_cnt - base == 3, "R9 three passes", wr_cnt - base, 3);

    // Self loop exiting on FIFO-full, re-execute set
    slot(0, 8'hB8, 8'h03, 8'h00, 8'h36);
    base = wr_cnt;
    start(16'd1);
    repeat (5) @(negedge clk);
    fifo_ready = 1'b0;
    wait_idle();
    fifo_ready = 1'b1;
    chk(wr_cnt - base == 5, "R8 re-execute set", wr_cnt - base, 5);

    // Same loop, re-execute clear
    wr({2'd0, 3'd0}, 8'h38);
    base = wr_cnt;
    start(16'd1);
    repeat (5) @(negedge clk);
    fifo_ready = 1'b0;
    wait_idle();
    fifo_ready = 1'b1;
    chk(wr_cnt - base == 1, "R8 re-execute clear", wr_cnt - base, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule